// File: doc/BRIEF.md
# USB Host Interrupt and Error Unit

This block holds the interrupt and error-status logic of a simple full-speed USB host controller. While the schedule engine walks the transfer list, it shows each descriptor's token PID and maximum-length field to this unit together with a valid strobe. A descriptor that fails either sanity check is logged as a process error, and the controller halts. Bus faults (parity error, master abort, target abort) are logged as host-system errors, and the Run/Stop command bit is forced low so that no further scheduled descriptors run. A resume signalled by a device during global suspend is logged as a resume-detect event.

The unit keeps the Run/Stop bit, a status register with write-1-to-clear event bits and a read-only halted bit, and a one-bit interrupt enable. It drives a single level interrupt. Both error classes interrupt whatever the enable holds. Resume is the only source that can be masked.

Top module: `usbh_irq_err_unit`

## Requirements
- R1: After reset, `run_stop` is 0, `status` is 4'b1000 (halted set, every event bit clear), `run_force_clr` is 0 and `irq` is 0.
- R2: While not halted, a valid descriptor whose PID is not 8'hE1, 8'h69 or 8'h2D sets the process-error bit `status[2]` and the halted bit `status[3]` on the next clock.
- R3: While not halted, a valid descriptor whose max-length field is 1280 or more sets `status[2]` and `status[3]` on the next clock. A value of 1279 or less raises no error.
- R4: While not halted, any of `bus_parity_err`, `bus_master_abort` or `bus_target_abort` sets the host-error bit `status[1]` and `status[3]`, drives `run_stop` to 0 and pulses `run_force_clr` high for one cycle, all on the next clock.
- R5: `resume_evt` sets the resume bit `status[0]` on the next clock, whether or not the unit is halted.
- R6: `irq` follows, one clock later, the OR of `status[2]`, `status[1]` and (`status[0]` AND the interrupt enable). The enable is loaded from `ien_wdata` when `ien_wr` is high.
- R7: With `sts_clr_wr` high, each bit i of `sts_clr_mask` clears `status[i]` (i = 0..2). A new event for the same bit in the same cycle wins, and unmasked bits are untouched.
- R8: Writing 0 to Run/Stop sets `status[3]`. Writing 1 clears `status[3]` only if `status[2]` and `status[1]` are both 0 at that time.
- R9: While `status[3]` is set, the descriptor strobe and bus error inputs neither change `status[2:1]` nor pulse `run_force_clr`.
- R10: `run_wr` loads `run_wdata` into `run_stop`. A bus error in the same cycle takes precedence and leaves `run_stop` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Descriptor fields valid this cycle |
| desc_pid | input | 8 | Token PID of the descriptor |
| desc_maxlen | input | LEN_W | Max-length field of the descriptor |
| resume_evt | input | 1 | Resume signalled by a device |
| bus_parity_err | input | 1 | Parity error strobe |
| bus_master_abort | input | 1 | Master abort strobe |
| bus_target_abort | input | 1 | Target abort strobe |
| run_wr | input | 1 | Software write of Run/Stop |
| run_wdata | input | 1 | Run/Stop value to write |
| sts_clr_wr | input | 1 | Software write-1-to-clear of status |
| sts_clr_mask | input | 3 | Bits of status[2:0] to clear |
| ien_wr | input | 1 | Software write of the resume interrupt enable |
| ien_wdata | input | 1 | Enable value to write |
| run_stop | output | 1 | Current Run/Stop bit |
| status | output | 4 | {halted, process error, host error, resume} |
| run_force_clr | output | 1 | One-cycle pulse when a bus error forced Run/Stop low |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the unit with the default LEN_W of 11 and a limit of 1280. That makes the whole max-length space of 2048 values small enough to sweep, and every value is checked against the limit, including the 1279/1280 edge. All 256 PID codes are swept as well, each followed by an interrupt check, so the valid-token decode is covered completely. Directed sequences then cover masking, the clear/event race, restart rules and the bus-error versus software-write precedence.

// File: rtl/usbh_irq_pkg.sv
package usbh_irq_pkg;

    localparam int STS_W = 4;

    typedef struct packed {
        logic halted;
        logic proc_err;
        logic host_err;
        logic resume;
    } usbh_sts_t;

    typedef enum logic [7:0] {
        TOK_SETUP = 8'h2D,
        TOK_IN    = 8'h69,
        TOK_OUT   = 8'hE1
    } usbh_tok_e;

    function automatic logic tok_is_legal(input logic [7:0] code);
        return (code == TOK_SETUP) || (code == TOK_IN) || (code == TOK_OUT);
    endfunction

endpackage

// File: rtl/usbh_desc_check.sv
module usbh_desc_check
    import usbh_irq_pkg::*;
#(
    parameter int LEN_W     = 11,
    parameter int LEN_LIMIT = 1280
) (
    input  logic [7:0]       pid,
    input  logic [LEN_W-1:0] maxlen,
    output logic             bad
);
    localparam logic [LEN_W:0] LIMIT_EXT = (LEN_W+1)'(LEN_LIMIT);

    logic pid_bad;
    logic len_bad;

    always_comb begin
        pid_bad = !tok_is_legal(pid);
        len_bad = {1'b0, maxlen} >= LIMIT_EXT;
        bad     = pid_bad || len_bad;
    end
endmodule

// File: rtl/usbh_sts_regs.sv
module usbh_sts_regs
    import usbh_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      proc_evt,
    input  logic      host_evt,
    input  logic      resume_evt,
    input  logic      clr_wr,
    input  logic [2:0] clr_mask,
    input  logic      run_wr,
    input  logic      run_wdata,
    output usbh_sts_t sts,
    output logic      run_stop,
    output logic      run_force_clr
);
    usbh_sts_t sts_q, sts_d;
    logic      run_q, run_d;
    logic      fclr_q;
    logic [2:0] clr_hit;

    always_comb begin
        clr_hit = clr_wr ? clr_mask : 3'b000;
        sts_d.resume   = resume_evt || (sts_q.resume   && !clr_hit[0]);
        sts_d.host_err = host_evt   || (sts_q.host_err && !clr_hit[1]);
        sts_d.proc_err = proc_evt   || (sts_q.proc_err && !clr_hit[2]);

        if (proc_evt || host_evt)
            sts_d.halted = 1'b1;
        else if (run_wr && !run_wdata)
            sts_d.halted = 1'b1;
        else if (run_wr && run_wdata && !sts_q.proc_err && !sts_q.host_err)
            sts_d.halted = 1'b0;
        else
            sts_d.halted = sts_q.halted;

        if (host_evt)
            run_d = 1'b0;
        else if (run_wr)
            run_d = run_wdata;
        else
            run_d = run_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q  <= '{halted: 1'b1, default: 1'b0};
            run_q  <= 1'b0;
            fclr_q <= 1'b0;
        end else begin
            sts_q  <= sts_d;
            run_q  <= run_d;
            fclr_q <= host_evt;
        end
    end

    assign sts           = sts_q;
    assign run_stop      = run_q;
    assign run_force_clr = fclr_q;
endmodule

// File: rtl/usbh_irq_gen.sv
module usbh_irq_gen
    import usbh_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  usbh_sts_t sts,
    input  logic      resume_en,
    output logic      irq
);
    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= sts.proc_err || sts.host_err || (sts.resume && resume_en);
    end

    assign irq = irq_q;
endmodule

// File: rtl/usbh_irq_err_unit.sv
module usbh_irq_err_unit
    import usbh_irq_pkg::*;
#(
    parameter int LEN_W     = 11,
    parameter int LEN_LIMIT = 1280
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             desc_valid,
    input  logic [7:0]       desc_pid,
    input  logic [LEN_W-1:0] desc_maxlen,
    input  logic             resume_evt,
    input  logic             bus_parity_err,
    input  logic             bus_master_abort,
    input  logic             bus_target_abort,
    input  logic             run_wr,
    input  logic             run_wdata,
    input  logic             sts_clr_wr,
    input  logic [2:0]       sts_clr_mask,
    input  logic             ien_wr,
    input  logic             ien_wdata,
    output logic             run_stop,
    output logic [STS_W-1:0] status,
    output logic             run_force_clr,
    output logic             irq
);
    usbh_sts_t sts;
    logic      desc_bad;
    logic      active;
    logic      bus_any;
    logic      proc_evt;
    logic      host_evt;
    logic      ien_q;

    usbh_desc_check #(.LEN_W(LEN_W), .LEN_LIMIT(LEN_LIMIT)) i_check (
        .pid    (desc_pid),
        .maxlen (desc_maxlen),
        .bad    (desc_bad)
    );

    always_comb begin
        active   = !sts.halted;
        bus_any  = bus_parity_err || bus_master_abort || bus_target_abort;
        proc_evt = active && desc_valid && desc_bad;
        host_evt = active && bus_any;
    end

    usbh_sts_regs i_regs (
        .clk           (clk),
        .rst           (rst),
        .proc_evt      (proc_evt),
        .host_evt      (host_evt),
        .resume_evt    (resume_evt),
        .clr_wr        (sts_clr_wr),
        .clr_mask      (sts_clr_mask),
        .run_wr        (run_wr),
        .run_wdata     (run_wdata),
        .sts           (sts),
        .run_stop      (run_stop),
        .run_force_clr (run_force_clr)
    );

    always_ff @(posedge clk) begin
        if (rst)         ien_q <= 1'b0;
        else if (ien_wr) ien_q <= ien_wdata;
    end

    usbh_irq_gen i_irq (
        .clk       (clk),
        .rst       (rst),
        .sts       (sts),
        .resume_en (ien_q),
        .irq       (irq)
    );

    assign status = sts;

    // R2 / R3: a failing descriptor while running is logged and halts
    a_r2_desc_logged: assert property (@(posedge clk) disable iff (rst)
        (!status[3] && desc_valid && desc_bad) |=> (status[2] && status[3]));

    // R4: bus error forces Run/Stop low with a pulse
    a_r4_bus_stops: assert property (@(posedge clk) disable iff (rst)
        (!status[3] && bus_any) |=> (!run_stop && status[1] && run_force_clr));

    // R5 / R7: resume always lands, even against a clear
    a_r5_resume_wins: assert property (@(posedge clk) disable iff (rst)
        resume_evt |=> status[0]);

    // R6: unmaskable errors drive the interrupt
    a_r6_err_irq: assert property (@(posedge clk) disable iff (rst)
        (status[2] || status[1]) |=> irq);

    // R6: no source means no interrupt
    a_r6_quiet: assert property (@(posedge clk) disable iff (rst)
        (!status[2] && !status[1] && !(status[0] && ien_q)) |=> !irq);

    // R9: errors are frozen while halted
    a_r9_halt_freeze: assert property (@(posedge clk) disable iff (rst)
        (status[3] && !sts_clr_wr) |=> ($stable(status[2:1]) && !run_force_clr));

    // R8: halted does not appear without a cause
    a_r8_no_spurious_halt: assert property (@(posedge clk) disable iff (rst)
        (!status[3] && !bus_any && !(desc_valid && desc_bad) && !(run_wr && !run_wdata))
        |=> !status[3]);
endmodule

// File: tb/test_usbh_irq_err_unit.sv
module test_usbh_irq_err_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        desc_valid = 1'b0;
    logic [7:0]  desc_pid = 8'h69;
    logic [10:0] desc_maxlen = 11'd64;
    logic        resume_evt = 1'b0;
    logic        bus_parity_err = 1'b0;
    logic        bus_master_abort = 1'b0;
    logic        bus_target_abort = 1'b0;
    logic        run_wr = 1'b0;
    logic        run_wdata = 1'b0;
    logic        sts_clr_wr = 1'b0;
    logic [2:0]  sts_clr_mask = 3'b000;
    logic        ien_wr = 1'b0;
    logic        ien_wdata = 1'b0;
    logic        run_stop;
    logic [3:0]  status;
    logic        run_force_clr;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    usbh_irq_err_unit i_usbh_irq_err_unit (
        .clk(clk), .rst(rst), .desc_valid(desc_valid), .desc_pid(desc_pid),
        .desc_maxlen(desc_maxlen), .resume_evt(resume_evt),
        .bus_parity_err(bus_parity_err), .bus_master_abort(bus_master_abort),
        .bus_target_abort(bus_target_abort), .run_wr(run_wr), .run_wdata(run_wdata),
        .sts_clr_wr(sts_clr_wr), .sts_clr_mask(sts_clr_mask), .ien_wr(ien_wr),
        .ien_wdata(ien_wdata), .run_stop(run_stop), .status(status),
        .run_force_clr(run_force_clr), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // clear every event bit, then start running
    task automatic restart();
        tick(); sts_clr_wr = 1'b1; sts_clr_mask = 3'b111;
        tick(); sts_clr_wr = 1'b0; sts_clr_mask = 3'b000; run_wr = 1'b1; run_wdata = 1'b1;
        tick(); run_wr = 1'b0;
    endtask

    task automatic send_desc(input logic [7:0] pid, input logic [10:0] len);
        tick(); desc_valid = 1'b1; desc_pid = pid; desc_maxlen = len;
        tick(); desc_valid = 1'b0; desc_pid = 8'h69; desc_maxlen = 11'd64;
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        check("R1 status", {28'd0, status}, 32'h8);
        check("R1 run_stop", {31'd0, run_stop}, 0);
        check("R1 irq", {31'd0, irq}, 0);
        check("R1 run_force_clr", {31'd0, run_force_clr}, 0);

        // R2 sweep of every PID code
        for (int p = 0; p < 256; p++) begin
            logic bad;
            bad = !(p == 8'hE1 || p == 8'h69 || p == 8'h2D);
            restart();
            send_desc(8'(p), 11'd64);
            check("R2 pid status", {28'd0, status}, bad ? 32'hC : 32'h0);
            tick();
            check("R6 pid irq", {31'd0, irq}, {31'd0, bad});
        end

        // R3 sweep of every max-length value
        for (int l = 0; l < 2048; l++) begin
            logic bad;
            bad = (l >= 1280);
            restart();
            send_desc(8'hE1, 11'(l));
            check("R3 maxlen status", {28'd0, status}, bad ? 32'hC : 32'h0);
        end

        // R4 each bus error source
        for (int k = 0; k < 3; k++) begin
            restart();
            tick();
            bus_parity_err = (k == 0); bus_master_abort = (k == 1); bus_target_abort = (k == 2);
            tick();
            bus_parity_err = 1'b0; bus_master_abort = 1'b0; bus_target_abort = 1'b0;
            check("R4 status", {28'd0, status}, 32'hA);
            check("R4 run_stop", {31'd0, run_stop}, 0);
            check("R4 pulse", {31'd0, run_force_clr}, 1);
            tick();
            check("R4 pulse ends", {31'd0, run_force_clr}, 0);
            check("R6 host irq", {31'd0, irq}, 1);
        end

        // R10 bus error beats a same-cycle write of 1
        restart();
        tick(); run_wr = 1'b1; run_wdata = 1'b1; bus_master_abort = 1'b1;
        tick(); run_wr = 1'b0; bus_master_abort = 1'b0;
        check("R10 precedence", {31'd0, run_stop}, 0);
        // R8 restart refused while host error pending
        tick(); run_wr = 1'b1; run_wdata = 1'b1;
        tick(); run_wr = 1'b0;
        check("R8 restart refused", {28'd0, status}, 32'hA);
        check("R10 write loads", {31'd0, run_stop}, 1);
        restart();
        check("R8 restart ok", {28'd0, status}, 32'h0);

        // R8 software stop halts; R9 inputs ignored while halted
        tick(); run_wr = 1'b1; run_wdata = 1'b0;
        tick(); run_wr = 1'b0;
        check("R8 sw stop halts", {28'd0, status}, 32'h8);
        check("R10 write 0", {31'd0, run_stop}, 0);
        tick(); desc_valid = 1'b1; desc_pid = 8'h00; bus_parity_err = 1'b1;
        tick(); desc_valid = 1'b0; desc_pid = 8'h69; bus_parity_err = 1'b0;
        check("R9 ignored status", {28'd0, status}, 32'h8);
        check("R9 no pulse", {31'd0, run_force_clr}, 0);
        tick();
        check("R9 no irq", {31'd0, irq}, 0);

        // R5 resume while halted, masked
        tick(); resume_evt = 1'b1;
        tick(); resume_evt = 1'b0;
        check("R5 resume halted", {28'd0, status}, 32'h9);
        tick();
        check("R6 masked", {31'd0, irq}, 0);
        tick(); ien_wr = 1'b1; ien_wdata = 1'b1;
        tick(); ien_wr = 1'b0;
        check("R6 enable lag", {31'd0, irq}, 0);
        tick();
        check("R6 enabled irq", {31'd0, irq}, 1);

        // R7 clear racing a new resume: event wins
        tick(); sts_clr_wr = 1'b1; sts_clr_mask = 3'b001; resume_evt = 1'b1;
        tick(); sts_clr_wr = 1'b0; resume_evt = 1'b0;
        check("R7 event wins", {31'd0, status[0]}, 1);
        tick(); sts_clr_wr = 1'b1; sts_clr_mask = 3'b001;
        tick(); sts_clr_wr = 1'b0;
        check("R7 cleared", {31'd0, status[0]}, 0);
        tick();
        check("R6 irq drops", {31'd0, irq}, 0);

        // R7 unmasked bits untouched
        restart();
        send_desc(8'h11, 11'd8);
        tick(); resume_evt = 1'b1;
        tick(); resume_evt = 1'b0; sts_clr_wr = 1'b1; sts_clr_mask = 3'b001;
        tick(); sts_clr_wr = 1'b0;
        check("R7 mask selective", {28'd0, status}, 32'hC);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule